// File: doc/BRIEF.md
# Block Address Translation Matcher

This block holds two small arrays of block translation entries, one consulted by instruction fetches and one by data reads and writes. Each entry is a pair of 32-bit registers. The upper register describes which effective region the entry covers and in which privilege states it may be used. The lower register gives the physical base of the region and its protection code. A lookup presents a 32-bit effective address, an access type and the privilege state. One cycle later the block returns either the real page address and the access rights of the first usable matching entry, or a miss.

Entries are loaded through a simple register write port. The port selects the array, the entry index and which register of the pair to write. Region sizes run from 128 KiB upward. The size is set by a length field that clears low-order bits from the compare mask. Addresses inside the region take their offset bits straight from the effective address.

Top module: `bat_matcher`

## Requirements
- R1: `acc_i` encodes 0 = read, 1 = write, 2 = fetch. A fetch searches only the instruction array. Reads and writes search only the data array.
- R2: Upper register bit 1 enables the entry in supervisor state (`user_i`=0) and bit 0 enables it in problem state (`user_i`=1). An entry whose bit for the current state is clear never hits.
- R3: Upper bits [31:17] hold the block's effective page and bits [12:2] hold the length field. The compare mask is 0xFFFE0000 with the length field, moved to bits [27:17], cleared from it. A usable entry hits when (ea AND mask) equals (upper AND 0xFFFE0000).
- R4: On a hit, `raddr_o` = ((lower AND mask) OR (ea AND NOT mask)) with bits [11:0] forced to zero. Bits [16:12] therefore always come from the effective address.
- R5: Lower bits [1:0] are the protection code. Code 0 grants nothing, codes 1 and 3 grant read and execute, and code 2 grants read, write and execute.
- R6: When several usable entries hit, the one with the lowest index supplies the result.
- R7: A request sampled on a clock edge yields `vld_o`=1 for exactly the following cycle, with the result registered. On a miss, `hit_o`, `raddr_o` and the rights outputs are all zero.
- R8: A register write applied on an edge is seen by lookups sampled on later edges. A lookup sampled on the same edge sees the old contents. `wr_instr_i`=1 selects the instruction array, and `wr_upper_i`=1 selects the upper register.
- R9: Reset clears every entry, so every lookup misses until entries are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry register write strobe |
| wr_instr_i | input | 1 | Write targets instruction array (1) or data array (0) |
| wr_idx_i | input | IDXW | Entry index to write |
| wr_upper_i | input | 1 | Write upper (1) or lower (0) register |
| wr_data_i | input | 32 | Write data |
| req_i | input | 1 | Lookup request |
| ea_i | input | 32 | Effective address |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| user_i | input | 1 | Problem state (1) or supervisor state (0) |
| vld_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | A usable entry matched |
| raddr_o | output | 32 | Real page address |
| rd_o | output | 1 | Read permitted |
| wr_o | output | 1 | Write permitted |
| ex_o | output | 1 | Execute permitted |

## Verification
Every lookup result is due exactly one clock edge after its request is sampled. Register writes become visible to a lookup sampled one edge after the write. The bench drives inputs on the falling edge, lets one rising edge pass, and samples all outputs on the next falling edge. It then drops the request so that the following edge produces no valid result. To check the write ordering, the bench drives a write and a lookup on the same falling edge, expects the old contents, and then repeats the lookup on the next edge to expect the new ones.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int unsigned AW        = 32;
  localparam logic [31:0] PG_MASK   = 32'hFFFE_0000;
  localparam logic [31:0] PAGE_MASK = 32'hFFFF_F000;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } rights_t;
endpackage

// File: rtl/bat_regfile.sv
module bat_regfile #(
  parameter int unsigned N    = 4,
  parameter int unsigned IDXW = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 wr_instr_i,
  input  logic [IDXW-1:0]      wr_idx_i,
  input  logic                 wr_upper_i,
  input  logic [31:0]          wr_data_i,
  input  logic                 sel_instr_i,
  output logic [N-1:0][31:0]   up_o,
  output logic [N-1:0][31:0]   lo_o
);
  logic [1:0][N-1:0][31:0] up_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= '0;
      lo_q <= '0;
    end else if (wr_en_i) begin
      if (wr_upper_i) up_q[wr_instr_i][wr_idx_i] <= wr_data_i;
      else            lo_q[wr_instr_i][wr_idx_i] <= wr_data_i;
    end
  end

  assign up_o = up_q[sel_instr_i];
  assign lo_o = lo_q[sel_instr_i];
endmodule

// File: rtl/bat_entry_eval.sv
module bat_entry_eval
  import bat_pkg::*;
(
  input  logic [31:0] up_i,
  input  logic [31:0] lo_i,
  input  logic [31:0] ea_i,
  input  logic        user_i,
  output logic        match_o,
  output logic [31:0] raddr_o,
  output rights_t     rights_o
);
  logic        usable;
  logic [31:0] len_sh, mask;

  assign usable  = user_i ? up_i[0] : up_i[1];
  assign len_sh  = {4'b0, up_i[12:2], 17'b0};
  assign mask    = PG_MASK & ~len_sh;
  assign match_o = usable && ((ea_i & mask) == (up_i & PG_MASK));
  assign raddr_o = ((lo_i & mask) | (ea_i & ~mask)) & PAGE_MASK;

  always_comb begin
    rights_o.r = |lo_i[1:0];
    rights_o.x = |lo_i[1:0];
    rights_o.w = (lo_i[1:0] == 2'd2);
  end
endmodule

// File: rtl/bat_first_hit.sv
module bat_first_hit #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] match_i,
  output logic [N-1:0] grant_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bat_matcher.sv
module bat_matcher
  import bat_pkg::*;
#(
  parameter int unsigned N    = 4,
  parameter int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_instr_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic            wr_upper_i,
  input  logic [31:0]     wr_data_i,
  input  logic            req_i,
  input  logic [31:0]     ea_i,
  input  logic [1:0]      acc_i,
  input  logic            user_i,
  output logic            vld_o,
  output logic            hit_o,
  output logic [31:0]     raddr_o,
  output logic            rd_o,
  output logic            wr_o,
  output logic            ex_o
);
  logic [N-1:0][31:0] up, lo, ent_raddr;
  rights_t [N-1:0]    ent_rights;
  logic [N-1:0]       match, grant;
  logic               sel_instr;
  logic [31:0]        raddr_d;
  rights_t            rights_d;

  assign sel_instr = (acc_i == ACC_FETCH);

  bat_regfile #(.N(N), .IDXW(IDXW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_instr_i, .wr_idx_i, .wr_upper_i, .wr_data_i,
    .sel_instr_i(sel_instr), .up_o(up), .lo_o(lo)
  );

  for (genvar g = 0; g < N; g++) begin : g_ent
    bat_entry_eval u_eval (
      .up_i(up[g]), .lo_i(lo[g]), .ea_i(ea_i), .user_i(user_i),
      .match_o(match[g]), .raddr_o(ent_raddr[g]), .rights_o(ent_rights[g])
    );
  end

  bat_first_hit #(.N(N)) u_prio (.match_i(match), .grant_o(grant));

  always_comb begin
    raddr_d  = '0;
    rights_d = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        raddr_d  = raddr_d | ent_raddr[i];
        rights_d = rights_d | ent_rights[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      hit_o   <= 1'b0;
      raddr_o <= '0;
      {rd_o, wr_o, ex_o} <= 3'b0;
    end else begin
      vld_o   <= req_i;
      hit_o   <= req_i && (|match);
      raddr_o <= req_i ? raddr_d : '0;
      {rd_o, wr_o, ex_o} <= req_i ? {rights_d.r, rights_d.w, rights_d.x} : 3'b0;
    end
  end

  assert_onehot_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && ((|grant) == (|match)));
  assert_req_to_vld_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);
  assert_no_req_no_vld_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o);
  assert_hit_needs_vld_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> vld_o);
  assert_miss_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (raddr_o == '0) && !rd_o && !wr_o && !ex_o);
  assert_page_align_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (raddr_o[11:0] == '0));
  assert_offset_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!hit_o || (raddr_o[16:12] == $past(ea_i[16:12]))));
  assert_write_implies_rx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> rd_o && ex_o);
endmodule

// File: tb/bat_matcher_tb.sv
module bat_matcher_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_instr_i = 1'b0, wr_upper_i = 1'b0;
  logic [1:0]  wr_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        req_i = 1'b0, user_i = 1'b0;
  logic [31:0] ea_i = '0;
  logic [1:0]  acc_i = '0;
  logic        vld_o, hit_o, rd_o, wr_o, ex_o;
  logic [31:0] raddr_o;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk_i = ~clk_i;

  bat_matcher dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_instr_i, .wr_idx_i, .wr_upper_i, .wr_data_i,
    .req_i, .ea_i, .acc_i, .user_i, .vld_o, .hit_o, .raddr_o, .rd_o, .wr_o, .ex_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_ent(bit instr, int idx, bit upper, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_instr_i = instr; wr_idx_i = 2'(idx);
    wr_upper_i = upper; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // result word: {vld, hit, r, w, x}
  task automatic lookup(string req, logic [31:0] ea, logic [1:0] acc, bit user,
                        logic [4:0] exp_flags, logic [31:0] exp_raddr);
    @(negedge clk_i);
    req_i = 1'b1; ea_i = ea; acc_i = acc; user_i = user;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(req, {27'b0, vld_o, hit_o, rd_o, wr_o, ex_o}, {27'b0, exp_flags});
    chk(req, raddr_o, exp_raddr);
  endtask

  task automatic t_reset;
    chk("R9 vld at reset", {31'b0, vld_o}, 32'd0);
    lookup("R9 empty miss", 32'h1001_2345, 2'd0, 1'b0, 5'b10000, 32'h0);
    @(negedge clk_i);
    chk("R7 vld drops", {31'b0, vld_o}, 32'd0);
  endtask

  task automatic t_load;
    write_ent(0, 0, 1, 32'h1000_0002); write_ent(0, 0, 0, 32'h8000_0002);
    write_ent(0, 1, 1, 32'h2000_003D); write_ent(0, 1, 0, 32'h9000_0001);
    write_ent(0, 2, 1, 32'h1000_0003); write_ent(0, 2, 0, 32'hA000_0003);
    write_ent(0, 3, 1, 32'h3000_0002); write_ent(0, 3, 0, 32'hB000_0000);
  endtask

  task automatic t_basic;
    lookup("R3 R4 R5 sup read hit", 32'h1001_2345, 2'd0, 1'b0, 5'b11111, 32'h8001_2000);
    lookup("R3 outside block", 32'h1002_0000, 2'd0, 1'b0, 5'b10000, 32'h0);
    lookup("R1 write uses data", 32'h1001_2345, 2'd1, 1'b0, 5'b11111, 32'h8001_2000);
    lookup("R1 fetch empty instr", 32'h1001_2345, 2'd2, 1'b0, 5'b10000, 32'h0);
  endtask

  task automatic t_size_priv;
    lookup("R3 R4 2MiB block", 32'h201A_B678, 2'd0, 1'b1, 5'b11101, 32'h901A_B000);
    lookup("R3 past 2MiB", 32'h2020_0000, 2'd0, 1'b1, 5'b10000, 32'h0);
    lookup("R2 user-only entry in sup", 32'h201A_B678, 2'd0, 1'b0, 5'b10000, 32'h0);
    lookup("R2 sup-only entry in user", 32'h3000_5000, 2'd0, 1'b1, 5'b10000, 32'h0);
  endtask

  task automatic t_prio_prot;
    lookup("R6 lowest index wins", 32'h1001_2345, 2'd0, 1'b0, 5'b11111, 32'h8001_2000);
    lookup("R6 R5 next usable code3", 32'h1001_2345, 2'd0, 1'b1, 5'b11101, 32'hA001_2000);
    lookup("R5 code0 no rights", 32'h3000_5000, 2'd0, 1'b0, 5'b11000, 32'hB000_5000);
  endtask

  task automatic t_instr;
    write_ent(1, 0, 1, 32'h1000_0002); write_ent(1, 0, 0, 32'hC000_0002);
    lookup("R1 fetch uses instr", 32'h1001_2345, 2'd2, 1'b0, 5'b11111, 32'hC001_2000);
    lookup("R1 read ignores instr", 32'h1001_2345, 2'd0, 1'b0, 5'b11111, 32'h8001_2000);
  endtask

  task automatic t_write_order;
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_instr_i = 1'b0; wr_idx_i = 2'd3; wr_upper_i = 1'b1;
    wr_data_i = 32'h4000_0002;
    req_i = 1'b1; ea_i = 32'h4000_0000; acc_i = 2'd0; user_i = 1'b0;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R8 same-edge old contents", {31'b0, hit_o}, 32'd0);
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R8 next-edge new contents", {31'b0, hit_o}, 32'd1);
    chk("R8 new raddr", raddr_o, 32'hB000_0000);
    lookup("R8 old page gone", 32'h3000_5000, 2'd0, 1'b0, 5'b10000, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_load;
    t_basic;
    t_size_priv;
    t_prio_prot;
    t_instr;
    t_write_order;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule